// File: doc/BRIEF.md
# Packed 8-bit dot-product accumulator

This integer datapath block takes two 32-bit operands, treats each as a vector of 8-bit lanes, multiplies the lanes pairwise and adds the lane products together. It then adds or subtracts a 32-bit third operand. The final value can either wrap to 32 bits or saturate at the limits of the selected number range. A control bit chooses between a 2-lane operation and a 4-lane operation. In 2-lane operation, a second bit chooses which 16-bit half of both operands supplies the lanes.

There are two number modes. In the unsigned mode every lane and the third operand are unsigned. In the mixed mode the lanes of the first operand are signed, the lanes of the second operand stay unsigned, and the third operand is a signed 32-bit value.

An operation is presented together with a valid strobe. The result appears two clocks later with its own strobe, and a new operation can be accepted on every clock.

Top module: `dp8acc_unit`

## Requirements
- R1: With `lanes4`=1 the result is src3 plus the sum of the four products src1[8k+7:8k] × src2[8k+7:8k] for k = 0..3.
- R2: With `lanes4`=0 only two lanes are used. When `pack_hi`=0 these are bytes 0 and 1 of both sources. When `pack_hi`=1 they are bytes 2 and 3.
- R3: With `lanes4`=1 the value of `pack_hi` has no effect on the result.
- R4: With `mode_mixed`=0 all lanes are unsigned 0..255 and src3 is unsigned 0..2^32-1.
- R5: With `mode_mixed`=1 the src1 lanes are two's-complement −128..127, the src2 lanes are unsigned 0..255, and src3 is a two's-complement 32-bit value.
- R6: With `acc_neg`=1 src3 is subtracted from the lane sum instead of added.
- R7: With `sat_en`=1 and `mode_mixed`=1 the exact result is clamped to −2^31..2^31−1. In-range values, including negative ones, pass through unchanged.
- R8: With `sat_en`=1 and `mode_mixed`=0 the exact result is clamped to 0..2^32−1, so a negative result gives 0.
- R9: With `sat_en`=0 the result is the exact value modulo 2^32.
- R10: `out_valid` is high exactly two clocks after an accepted `in_valid`, and back-to-back operations are accepted. `result` holds its value while no operation completes.
- R11: A synchronous reset clears both pipeline valid flags and sets `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| src1 | input | 32 | Lane vector, signed lanes in mixed mode |
| src2 | input | 32 | Lane vector, always unsigned lanes |
| src3 | input | 32 | Accumulator operand |
| mode_mixed | input | 1 | 0 unsigned, 1 mixed signedness |
| lanes4 | input | 1 | 0 two lanes, 1 four lanes |
| pack_hi | input | 1 | Two-lane half select: 0 low, 1 high |
| acc_neg | input | 1 | Subtract src3 instead of adding it |
| sat_en | input | 1 | Clamp instead of wrapping |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Accumulated dot product |

## Verification
The bench builds the block with its default parameters: 8-bit lanes and four lanes per source, so both the 2-lane and the 4-lane selection paths are present. With these widths, extreme operands drive the exact sum past both ends of the unsigned and the signed 32-bit ranges. This lets the bench check the clamping corners and the wrap corners against hand-computed values. One of these corners is the negation of the most negative signed accumulator. The bench also streams its vectors back to back, holds the inputs idle after them, and applies a reset while an operation is still in flight.

// File: rtl/dp8acc_pkg.sv
package dp8acc_pkg;
   // control bits that travel with the lane sum into the second stage
   typedef struct packed {
      logic mixed;
      logic neg;
      logic sat;
   } dp8acc_ctrl_t;
endpackage

// File: rtl/dp8acc_lane_mul.sv
module dp8acc_lane_mul #(
   parameter int LANE_W = 8,
   localparam int PROD_W = 2 * LANE_W + 2
) (
   input  logic                     mixed,
   input  logic                     en,
   input  logic [LANE_W-1:0]        a,
   input  logic [LANE_W-1:0]        b,
   output logic signed [PROD_W-1:0] prod
);
   logic signed [LANE_W:0]   a_x;
   logic signed [LANE_W:0]   b_x;
   logic signed [PROD_W-1:0] p;

   always_comb begin
      // the first operand is sign-extended only in the mixed mode
      a_x  = {mixed & a[LANE_W-1], a};
      b_x  = {1'b0, b};
      p    = a_x * b_x;
      prod = en ? p : '0;
   end
endmodule

// File: rtl/dp8acc_front.sv
module dp8acc_front
   import dp8acc_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int SRC_W  = LANE_W * LANES,
   localparam int PROD_W = 2 * LANE_W + 2,
   localparam int SUM_W  = PROD_W + $clog2(LANES)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [SRC_W-1:0]        src1,
   input  logic [SRC_W-1:0]        src2,
   input  logic [SRC_W-1:0]        src3,
   input  logic                    lanes4,
   input  logic                    pack_hi,
   input  dp8acc_ctrl_t            ctrl_in,
   output logic                    s1_valid,
   output logic signed [SUM_W-1:0] s1_sum,
   output logic [SRC_W-1:0]        s1_acc,
   output dp8acc_ctrl_t            s1_ctrl
);
   localparam int HALF = LANES / 2;

   logic signed [PROD_W-1:0] prod [LANES];
   logic signed [SUM_W-1:0]  lane_sum;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam bit UPPER = (i >= HALF);
      logic lane_en;
      // every lane in wide mode, otherwise only the selected half
      assign lane_en = lanes4 | (pack_hi == UPPER);
      dp8acc_lane_mul #(.LANE_W(LANE_W)) mul_i (
         .mixed (ctrl_in.mixed),
         .en    (lane_en),
         .a     (src1[i*LANE_W +: LANE_W]),
         .b     (src2[i*LANE_W +: LANE_W]),
         .prod  (prod[i])
      );
   end

   always_comb begin
      lane_sum = '0;
      for (int k = 0; k < LANES; k++) begin
         lane_sum = lane_sum + SUM_W'(prod[k]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_sum   <= '0;
         s1_acc   <= '0;
         s1_ctrl  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_sum  <= lane_sum;
            s1_acc  <= src3;
            s1_ctrl <= ctrl_in;
         end
      end
   end

   // R10: an accepted operation reaches the second stage one clock later
   a_r10_stage1_follow : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> s1_valid);
   a_r10_stage1_idle : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !s1_valid);
endmodule

// File: rtl/dp8acc_back.sv
module dp8acc_back
   import dp8acc_pkg::*;
#(
   parameter int ACC_W = 32,
   parameter int SUM_W = 20,
   localparam int EXT_W = ((ACC_W > SUM_W) ? ACC_W : SUM_W) + 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    s1_valid,
   input  logic signed [SUM_W-1:0] s1_sum,
   input  logic [ACC_W-1:0]        s1_acc,
   input  dp8acc_ctrl_t            s1_ctrl,
   output logic                    out_valid,
   output logic [ACC_W-1:0]        result
);
   localparam logic signed [EXT_W-1:0] S_MAX =
      {{(EXT_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
   localparam logic signed [EXT_W-1:0] S_MIN =
      {{(EXT_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
   localparam logic signed [EXT_W-1:0] U_MAX =
      {{(EXT_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};

   logic signed [EXT_W-1:0] acc_x;
   logic signed [EXT_W-1:0] sum_x;
   logic signed [EXT_W-1:0] total;
   logic signed [EXT_W-1:0] clamped;

   always_comb begin
      acc_x = {{(EXT_W-ACC_W){s1_ctrl.mixed & s1_acc[ACC_W-1]}}, s1_acc};
      sum_x = {{(EXT_W-SUM_W){s1_sum[SUM_W-1]}}, s1_sum};
      total = sum_x + (s1_ctrl.neg ? -acc_x : acc_x);
      clamped = total;
      if (s1_ctrl.sat) begin
         if (s1_ctrl.mixed) begin
            if (total > S_MAX)      clamped = S_MAX;
            else if (total < S_MIN) clamped = S_MIN;
         end else begin
            if (total > U_MAX)      clamped = U_MAX;
            else if (total < 0)     clamped = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) result <= clamped[ACC_W-1:0];
      end
   end

   // R10: completion strobe one clock after the first stage
   a_r10_out_follow : assert property (@(posedge clk) disable iff (rst)
      s1_valid |=> out_valid);
   // R10: result holds while nothing completes
   a_r10_hold : assert property (@(posedge clk) disable iff (rst)
      !s1_valid |=> $stable(result));
   // R8: negative exact value in unsigned saturation gives zero
   a_r8_neg_clamp : assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_ctrl.sat && !s1_ctrl.mixed && total < 0) |=> result == '0);
   // R7: above the signed ceiling the result is the ceiling
   a_r7_pos_clamp : assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_ctrl.sat && s1_ctrl.mixed && total > S_MAX)
      |=> result == S_MAX[ACC_W-1:0]);
   // R9: without saturation the low bits of the exact value appear
   a_r9_wrap : assert property (@(posedge clk) disable iff (rst)
      (s1_valid && !s1_ctrl.sat) |=> result == $past(total[ACC_W-1:0]));
endmodule

// File: rtl/dp8acc_unit.sv
module dp8acc_unit
   import dp8acc_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int SRC_W  = LANE_W * LANES,
   localparam int PROD_W = 2 * LANE_W + 2,
   localparam int SUM_W  = PROD_W + $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [SRC_W-1:0] src1,
   input  logic [SRC_W-1:0] src2,
   input  logic [SRC_W-1:0] src3,
   input  logic             mode_mixed,
   input  logic             lanes4,
   input  logic             pack_hi,
   input  logic             acc_neg,
   input  logic             sat_en,
   output logic             out_valid,
   output logic [SRC_W-1:0] result
);
   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("dp8acc_unit: LANES must be even and at least 2");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("dp8acc_unit: LANE_W must be at least 2");
   end

   dp8acc_ctrl_t            ctrl_in;
   dp8acc_ctrl_t            s1_ctrl;
   logic                    s1_valid;
   logic signed [SUM_W-1:0] s1_sum;
   logic [SRC_W-1:0]        s1_acc;

   assign ctrl_in = '{mixed: mode_mixed, neg: acc_neg, sat: sat_en};

   dp8acc_front #(.LANE_W(LANE_W), .LANES(LANES)) front_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .src1     (src1),
      .src2     (src2),
      .src3     (src3),
      .lanes4   (lanes4),
      .pack_hi  (pack_hi),
      .ctrl_in  (ctrl_in),
      .s1_valid (s1_valid),
      .s1_sum   (s1_sum),
      .s1_acc   (s1_acc),
      .s1_ctrl  (s1_ctrl)
   );

   dp8acc_back #(.ACC_W(SRC_W), .SUM_W(SUM_W)) back_i (
      .clk       (clk),
      .rst       (rst),
      .s1_valid  (s1_valid),
      .s1_sum    (s1_sum),
      .s1_acc    (s1_acc),
      .s1_ctrl   (s1_ctrl),
      .out_valid (out_valid),
      .result    (result)
   );
endmodule

// File: tb/dp8acc_unit_tb_top.sv
module dp8acc_unit_tb_top;
   localparam int PERIOD = 10;
   localparam int NV = 16;

   typedef struct packed {
      logic [31:0] s1;
      logic [31:0] s2;
      logic [31:0] s3;
      logic mx, l4, hi, ng, st;
      logic [31:0] exp;
   } vec_t;

   // expected values worked out by hand from the requirements
   localparam vec_t TBL [NV] = '{
      '{32'h04030201, 32'h08070605, 32'h0000000A, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h00000050}, // R1 70+10
      '{32'h04030201, 32'h08070605, 32'h0000000A, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000001B}, // R2 low 17+10
      '{32'h04030201, 32'h08070605, 32'h0000000A, 1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0000003F}, // R2 high 53+10
      '{32'h04030201, 32'h08070605, 32'h0000000A, 1'b0,1'b1,1'b1,1'b0,1'b0, 32'h00000050}, // R3 pack ignored
      '{32'hFF807F01, 32'h02030405, 32'hFFFFFFF6, 1'b1,1'b1,1'b0,1'b0,1'b0, 32'h00000075}, // R5 127-10
      '{32'hFF807F01, 32'h02030405, 32'hFFFFFFF6, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h00000575}, // R4 1407+big wraps
      '{32'h04030201, 32'h08070605, 32'h00000064, 1'b0,1'b1,1'b0,1'b1,1'b0, 32'hFFFFFFE2}, // R6 70-100
      '{32'h04030201, 32'h08070605, 32'h00000064, 1'b0,1'b1,1'b0,1'b1,1'b1, 32'h00000000}, // R8 negative to 0
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0,1'b1,1'b0,1'b0,1'b1, 32'hFFFFFFFF}, // R8 ceiling
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0003F803}, // R9 wrap
      '{32'h7F7F7F7F, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1,1'b1,1'b0,1'b0,1'b1, 32'h7FFFFFFF}, // R7 high clamp
      '{32'h80808080, 32'hFFFFFFFF, 32'h80000000, 1'b1,1'b1,1'b0,1'b0,1'b1, 32'h80000000}, // R7 low clamp
      '{32'h00000000, 32'h12345678, 32'h80000000, 1'b1,1'b1,1'b0,1'b1,1'b1, 32'h7FFFFFFF}, // R7 R6 -min clamps
      '{32'h7F7F7F7F, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1,1'b1,1'b0,1'b0,1'b0, 32'h8001FA03}, // R9 signed wrap
      '{32'h80FF0000, 32'h0A141111, 32'h00000000, 1'b1,1'b0,1'b1,1'b0,1'b0, 32'hFFFFFAEC}, // R5 R2 high mixed
      '{32'h000000FE, 32'h00000003, 32'h00000005, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'hFFFFFFFF}  // R7 in range -1
   };
   localparam string TAG [NV] = '{"R1","R2","R2","R3","R5","R4","R6","R8",
                                  "R8","R9","R7","R7","R7","R9","R5","R7"};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [31:0] src1 = '0, src2 = '0, src3 = '0;
   logic mode_mixed = 1'b0, lanes4 = 1'b0, pack_hi = 1'b0, acc_neg = 1'b0, sat_en = 1'b0;
   logic out_valid;
   logic [31:0] result;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk = ~clk;

   dp8acc_unit dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .src1(src1), .src2(src2), .src3(src3),
      .mode_mixed(mode_mixed), .lanes4(lanes4), .pack_hi(pack_hi),
      .acc_neg(acc_neg), .sat_en(sat_en),
      .out_valid(out_valid), .result(result)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic vld);
      in_valid   = vld;
      src1       = v.s1;
      src2       = v.s2;
      src3       = v.s3;
      mode_mixed = v.mx;
      lanes4     = v.l4;
      pack_hi    = v.hi;
      acc_neg    = v.ng;
      sat_en     = v.st;
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11: reset state
      check("R11", {31'b0, out_valid}, 32'd0);
      check("R11", result, 32'd0);

      // pipelined walk through the table, one operation per clock (R10)
      for (int j = 0; j < NV + 2; j++) begin
         @(negedge clk);
         if (j >= 2) begin
            check("R10", {31'b0, out_valid}, 32'd1);
            check(TAG[j-2], result, TBL[j-2].exp);
         end
         if (j < NV) drive(TBL[j], 1'b1);
         else        drive(TBL[0], 1'b0);
      end

      // R10: latency of a single operation and hold afterwards
      @(negedge clk);
      drive(TBL[2], 1'b1);
      @(negedge clk);
      drive(TBL[9], 1'b0);
      check("R10", {31'b0, out_valid}, 32'd0);
      @(negedge clk);
      check("R10", {31'b0, out_valid}, 32'd1);
      check("R2", result, 32'h0000003F);
      held = result;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         src1 = src1 ^ 32'h5A5A5A5A;
         check("R10", {31'b0, out_valid}, 32'd0);
         check("R10", result, held);
      end

      // R11: reset while an operation is in flight
      @(negedge clk);
      drive(TBL[0], 1'b1);
      @(negedge clk);
      drive(TBL[0], 1'b0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R11", {31'b0, out_valid}, 32'd0);
      check("R11", result, 32'd0);
      @(negedge clk);
      check("R11", {31'b0, out_valid}, 32'd0);
      check("R11", result, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule